// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

This block turns a set of synchronous interrupt input lines into message writes. Software reaches it through a 64-bit register window with three registers: an index register, a data window that opens one entry of a 32-entry table, and an end-of-interrupt register. Each input line owns two table entries. The low entry holds the vector and the control flags. The high entry holds the destination address in a packed form, with its two address bytes stored in swapped positions.

When a line rises while it is enabled, the block sets a bit in a latched-interrupt vector. If that bit was clear, it queues a message write that carries the vector to the unpacked destination. Queued messages leave one at a time on a valid/ready port, lowest line first. A falling line clears its latched bit. An end-of-interrupt write clears the latched bit of every line whose programmed vector equals the value written. The latched vector is brought out as a port so the surrounding logic can watch it.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: Every request gets a response exactly one cycle later (`resp_valid`). With `req_wide` = 0 the access is 32 bits and address bit 2 picks the half. A read returns that half in bits [31:0] with zeros above. A write merges `req_wdata[31:0]` into that half only.
- R2: Offset 0x800 is the index register (read/write). Offset 0x810 is the data window onto table entry number index, when index < 32.
- R3: Reading the window while the index equals 1 returns 0x0000_0000_0020_0001 (entry count 32 in bits [31:16], revision 1), whatever is stored in entry 1.
- R4: A window access with index >= 32, or an access to any offset other than 0x800, 0x810 and 0x840, sets `resp_err`. A read then returns all ones and a write changes nothing. Reading 0x840 returns zero with no error.
- R5: Line i uses entry 0x10+2i as its low word and 0x11+2i as its high word. A rising edge on line i sets latched bit (vector & 7), where the vector is low-word bits [5:0], only when low-word bit 16 (mask) is clear and high-word bits [31:16] are nonzero. A message is queued only if that bit was clear before.
- R6: A falling edge on line i, or a rising edge while it is masked or its destination is zero, clears latched bit (vector & 7).
- R7: A write to 0x840 takes `req_wdata[5:0]`. Every line i whose vector equals that value has latched bit i cleared. The clear wins over a set in the same cycle.
- R8: A queued message keeps `msg_valid` high until `msg_ready`. At most one message is accepted per cycle, and the lowest-numbered pending line goes first.
- R9: The message address is {4'hF, high[23:16], high[31:24], 12'h000}. The message data is the line's vector (low-word bits [5:0]).
- R10: After reset the latched vector is zero, the index is zero, and no message is pending. Low word i is 0x1A000 | (i+2): masked, level, active-low, vector i+2. High word i is 0xA0FF0000, the packed form of 0xFFFA0000. All other entries are zero.
- R11: A line held high does not raise a new message after its latched bit is cleared by end-of-interrupt. Only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | 10 | Byte address bits [11:2] |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_rdata | output | 64 | Read data |
| resp_err | output | 1 | Access hit no valid target |
| irq_in | input | 8 | Interrupt input lines, sampled on the clock |
| latched | output | 8 | Latched-interrupt vector |
| msg_valid | output | 1 | Message write pending |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 32 | Unpacked destination address |
| msg_data | output | 6 | Vector carried by the message |

## Verification
The bench programs two lines with vectors that share one latched bit. A design that keys the "already latched" test on the line, not on the bit, would send a second message. It also sends end-of-interrupt while the lines stay high. A level-sensitive design would fire again at once, and one that clears by bit instead of by line index would leave the wrong bit set. Simultaneous rises with the port stalled check lowest-first ordering and that messages are held. A custom packed destination catches swapped byte fields, and a 32-bit upper-half write catches a merge that clobbers the other half.

// File: rtl/irc_pkg.sv
// Package: shared constants and helpers for the interrupt redirection controller.
// Assumes 64-bit registers on an 8-byte grid and a 6-bit vector field.
package irc_pkg;
    localparam logic [8:0]  OFF_INDEX  = 9'h100;   // byte offset 0x800
    localparam logic [8:0]  OFF_WINDOW = 9'h102;   // byte offset 0x810
    localparam logic [8:0]  OFF_EOI    = 9'h108;   // byte offset 0x840
    localparam logic [63:0] VERSION_WORD = 64'h0000_0000_0020_0001;
    localparam int          LINE_BASE  = 16;
    localparam logic [31:0] LO_DEFAULT_FLAGS = 32'h0001_A000;

    // Merge write data into a 64-bit register by access width and half.
    function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                            input logic [63:0] wd,
                                            input logic wide, input logic upper);
        if (wide)       merge64 = wd;
        else if (upper) merge64 = {wd[31:0], old_v[31:0]};
        else            merge64 = {old_v[63:32], wd[31:0]};
    endfunction

    // Select the returned half of a register for a 32-bit read.
    function automatic logic [63:0] pick_half(input logic [63:0] v,
                                              input logic wide, input logic upper);
        if (wide)       pick_half = v;
        else if (upper) pick_half = {32'h0, v[63:32]};
        else            pick_half = {32'h0, v[31:0]};
    endfunction

    // Pack a destination address into the stored high-word form.
    function automatic logic [31:0] pack_dest(input logic [31:0] a);
        pack_dest = {a[19:12], a[27:20], 16'h0};
    endfunction

    // Restore the destination address from the stored high-word form.
    function automatic logic [31:0] unpack_dest(input logic [31:0] h);
        unpack_dest = {4'hF, h[23:16], h[31:24], 12'h000};
    endfunction
endpackage

// File: rtl/irc_regfile.sv
// Register file: index register, windowed table, end-of-interrupt decode.
// Assumes TAB_N >= 16 + 2*NLINES and that every request is answered next cycle.
module irc_regfile
    import irc_pkg::*;
#(
    parameter int          NLINES   = 8,
    parameter int          TAB_N    = 32,
    parameter logic [31:0] DEF_DEST = 32'hFFFA_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic                        req_wide,
    input  logic [11:2]                 req_addr,
    input  logic [63:0]                 req_wdata,
    output logic                        resp_valid,
    output logic [63:0]                 resp_rdata,
    output logic                        resp_err,
    output logic                        eoi_stb,
    output logic [5:0]                  eoi_val,
    output logic [NLINES-1:0][5:0]      line_vec,
    output logic [NLINES-1:0]           line_mask,
    output logic [NLINES-1:0][15:0]     line_dest,
    output logic [NLINES-1:0][31:0]     line_hi
);
    localparam int SEL_W = $clog2(TAB_N);

    logic [TAB_N-1:0][63:0] tab_q;
    logic [63:0]            idx_q;
    logic [8:0]             off;
    logic                   upper, is_idx, is_win, is_eoi, idx_ok;
    logic [SEL_W-1:0]       idx;
    logic [63:0]            raw;
    logic                   err;

    // Reset value of one table entry.
    function automatic logic [63:0] entry_default(input int k);
        entry_default = 64'h0;
        if (k >= LINE_BASE && k < LINE_BASE + 2*NLINES) begin
            if (((k - LINE_BASE) % 2) == 0)
                entry_default = {32'h0, LO_DEFAULT_FLAGS | 32'((k - LINE_BASE)/2 + 2)};
            else
                entry_default = {32'h0, pack_dest(DEF_DEST)};
        end
    endfunction

    // Address decode of the request.
    always_comb begin
        off    = req_addr[11:3];
        upper  = req_addr[2];
        is_idx = (off == OFF_INDEX);
        is_win = (off == OFF_WINDOW);
        is_eoi = (off == OFF_EOI);
        idx_ok = (idx_q < 64'(TAB_N));
        idx    = idx_q[SEL_W-1:0];
        err    = (is_win && !idx_ok) || !(is_idx || is_win || is_eoi);
    end

    // Read data selection before half picking.
    always_comb begin
        raw = '1;
        if (is_idx)
            raw = idx_q;
        else if (is_win && idx_ok)
            raw = (idx_q == 64'd1) ? VERSION_WORD : tab_q[idx];
        else if (is_eoi)
            raw = 64'h0;
    end

    // End-of-interrupt strobe toward the latch logic.
    assign eoi_stb = req_valid && req_write && is_eoi;
    assign eoi_val = req_wdata[5:0];

    // Index register and table storage with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int k = 0; k < TAB_N; k++) tab_q[k] <= entry_default(k);
        end else if (req_valid && req_write) begin
            if (is_idx)
                idx_q <= merge64(idx_q, req_wdata, req_wide, upper);
            else if (is_win && idx_ok)
                tab_q[idx] <= merge64(tab_q[idx], req_wdata, req_wide, upper);
        end
    end

    // Response register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            resp_err   <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_err   <= req_valid && err;
            resp_rdata <= (req_valid && !req_write) ? pick_half(raw, req_wide, upper) : '0;
        end
    end

    // Per-line views of the redirection entries.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign line_vec[i]  = tab_q[LINE_BASE + 2*i][5:0];
        assign line_mask[i] = tab_q[LINE_BASE + 2*i][16];
        assign line_dest[i] = tab_q[LINE_BASE + 2*i + 1][31:16];
        assign line_hi[i]   = tab_q[LINE_BASE + 2*i + 1][31:0];
    end

    AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R1
    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_wide && is_win && idx_q == 64'd1
        |=> resp_rdata == VERSION_WORD && !resp_err); // R3
endmodule

// File: rtl/irc_latch.sv
// Latch logic: edge detection, latched-interrupt vector, EOI clears, pending set.
// Assumes NLINES is a power of two; one event per line per cycle.
module irc_latch #(
    parameter int NLINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        irq_in,
    input  logic [NLINES-1:0][5:0]   line_vec,
    input  logic [NLINES-1:0]        line_mask,
    input  logic [NLINES-1:0][15:0]  line_dest,
    input  logic                     eoi_stb,
    input  logic [5:0]               eoi_val,
    input  logic [NLINES-1:0]        grant,
    output logic [NLINES-1:0]        latched,
    output logic [NLINES-1:0]        pend
);
    localparam int IDX_W = $clog2(NLINES);

    logic [NLINES-1:0] irq_q, rise, fall, lat_nxt, new_p;
    logic [IDX_W-1:0]  b;

    assign rise = irq_in & ~irq_q;
    assign fall = ~irq_in & irq_q;

    // Next latched vector and new messages, lines in ascending order, EOI last.
    always_comb begin
        lat_nxt = latched;
        new_p   = '0;
        b       = '0;
        for (int i = 0; i < NLINES; i++) begin
            b = line_vec[i][IDX_W-1:0];
            if (rise[i] && !line_mask[i] && line_dest[i] != 16'h0) begin
                if (!lat_nxt[b]) new_p[i] = 1'b1;
                lat_nxt[b] = 1'b1;
            end else if (rise[i] || fall[i]) begin
                lat_nxt[b] = 1'b0;
            end
        end
        if (eoi_stb)
            for (int i = 0; i < NLINES; i++)
                if (line_vec[i] == eoi_val) lat_nxt[i] = 1'b0;
    end

    // State registers: input sample, latched vector, pending messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= '0;
            latched <= '0;
            pend    <= '0;
        end else begin
            irq_q   <= irq_in;
            latched <= lat_nxt;
            pend    <= (pend & ~grant) | new_p;
        end
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_chk
        AST_MSG_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(irq_in[i] && !irq_q[i] && !line_mask[i])); // R5
        AST_EOI_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_stb && line_vec[i] == eoi_val |=> !latched[i]); // R7
    end
endmodule

// File: rtl/irc_msg_arb.sv
// Message arbiter: picks the lowest pending line and drives the message port.
// Assumes pending bits stay set until granted.
module irc_msg_arb
    import irc_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        pend,
    input  logic [NLINES-1:0][5:0]   line_vec,
    input  logic [NLINES-1:0][31:0]  line_hi,
    input  logic                     msg_ready,
    output logic [NLINES-1:0]        grant,
    output logic                     msg_valid,
    output logic [31:0]              msg_addr,
    output logic [5:0]               msg_data
);
    logic              found;
    logic [NLINES-1:0] pick;

    // Lowest-index pending line wins.
    always_comb begin
        found    = 1'b0;
        pick     = '0;
        msg_addr = '0;
        msg_data = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (pend[i] && !found) begin
                found    = 1'b1;
                pick[i]  = 1'b1;
                msg_addr = unpack_dest(line_hi[i]);
                msg_data = line_vec[i];
            end
        end
    end

    assign msg_valid = |pend;
    assign grant     = msg_ready ? pick : '0;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid); // R8
endmodule

// File: rtl/irq_redirect_ctrl.sv
// Top: indexed interrupt redirection controller.
// Assumes synchronous inputs and a consumer on the message port that may stall.
module irq_redirect_ctrl
    import irc_pkg::*;
#(
    parameter int          NLINES   = 8,
    parameter int          TAB_N    = 32,
    parameter logic [31:0] DEF_DEST = 32'hFFFA_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [11:2]       req_addr,
    input  logic [63:0]       req_wdata,
    output logic              resp_valid,
    output logic [63:0]       resp_rdata,
    output logic              resp_err,
    input  logic [NLINES-1:0] irq_in,
    output logic [NLINES-1:0] latched,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [31:0]       msg_addr,
    output logic [5:0]        msg_data
);
    logic                    eoi_stb;
    logic [5:0]              eoi_val;
    logic [NLINES-1:0][5:0]  line_vec;
    logic [NLINES-1:0]       line_mask;
    logic [NLINES-1:0][15:0] line_dest;
    logic [NLINES-1:0][31:0] line_hi;
    logic [NLINES-1:0]       pend, grant;

    irc_regfile #(.NLINES(NLINES), .TAB_N(TAB_N), .DEF_DEST(DEF_DEST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .eoi_stb(eoi_stb), .eoi_val(eoi_val),
        .line_vec(line_vec), .line_mask(line_mask), .line_dest(line_dest),
        .line_hi(line_hi)
    );

    irc_latch #(.NLINES(NLINES)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .line_vec(line_vec), .line_mask(line_mask), .line_dest(line_dest),
        .eoi_stb(eoi_stb), .eoi_val(eoi_val), .grant(grant),
        .latched(latched), .pend(pend)
    );

    irc_msg_arb #(.NLINES(NLINES)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .line_vec(line_vec), .line_hi(line_hi), .msg_ready(msg_ready),
        .grant(grant), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );
endmodule

// File: tb/tb_irq_redirect_ctrl.sv
module tb_irq_redirect_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [11:2] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        resp_valid, resp_err;
    logic [63:0] resp_rdata;
    logic [7:0]  irq_in = '0;
    logic [7:0]  latched;
    logic        msg_valid, msg_ready = 1'b1;
    logic [31:0] msg_addr;
    logic [5:0]  msg_data;

    int checks = 0;
    int bad = 0;
    logic [31:0] exp_addr[$];
    logic [5:0]  exp_data[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_redirect_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .irq_in(irq_in), .latched(latched), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every accepted message.
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            checks++;
            if (exp_addr.size() == 0) begin
                bad++;
                $display("FAIL R5 unexpected message: actual=%h/%0d expected=none", msg_addr, msg_data);
            end else begin
                if (msg_addr !== exp_addr[0] || msg_data !== exp_data[0]) begin
                    bad++;
                    $display("FAIL R9 message: actual=%h/%0d expected=%h/%0d",
                             msg_addr, msg_data, exp_addr[0], exp_data[0]);
                end
                void'(exp_addr.pop_front());
                void'(exp_data.pop_front());
            end
        end
    end

    task automatic expect_msg(input logic [31:0] a, input logic [5:0] d);
        exp_addr.push_back(a);
        exp_data.push_back(d);
    endtask

    task automatic access(input logic wr, input logic wide, input logic [11:0] addr,
                          input logic [63:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_addr = addr[11:2]; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = resp_rdata; er = resp_err;
        checks++;
        if (resp_valid !== 1'b1) begin
            bad++;
            $display("FAIL R1 response missing: actual=%b expected=1", resp_valid);
        end
    endtask

    task automatic wr(input logic wide, input logic [11:0] addr, input logic [63:0] wd,
                      input logic exp_err, input string req);
        logic [63:0] rd; logic er;
        access(1'b1, wide, addr, wd, rd, er);
        check(req, {63'h0, er}, {63'h0, exp_err});
    endtask

    task automatic rdchk(input logic wide, input logic [11:0] addr, input logic [63:0] exp,
                         input logic exp_err, input string req);
        logic [63:0] rd; logic er;
        access(1'b0, wide, addr, 64'h0, rd, er);
        check(req, rd, exp);
        check(req, {63'h0, er}, {63'h0, exp_err});
    endtask

    task automatic set_entry(input int k, input logic [63:0] v);
        wr(1'b1, 12'h800, 64'(k), 1'b0, "R2 index write");
        wr(1'b1, 12'h810, v, 1'b0, "R2 window write");
    endtask

    task automatic read_entry(input int k, input logic [63:0] exp, input string req);
        wr(1'b1, 12'h800, 64'(k), 1'b0, "R2 index write");
        rdchk(1'b1, 12'h810, exp, 1'b0, req);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 latched", {56'h0, latched}, 64'h0);
        check("R10 no message", {63'h0, msg_valid}, 64'h0);
        rdchk(1'b1, 12'h800, 64'h0, 1'b0, "R10 index reset");
        read_entry(16, 64'h1A002, "R10 line0 low");
        read_entry(17, 64'hA0FF0000, "R10 line0 high");
        read_entry(22, 64'h1A005, "R10 line3 low");
        read_entry(3, 64'h0, "R10 plain entry");
        // R3 version word
        read_entry(1, 64'h200001, "R3 version 64-bit");
        rdchk(1'b0, 12'h814, 64'h0, 1'b0, "R3 version upper half");
        // R1 half accesses
        set_entry(5, 64'h1111_2222_3333_4444);
        wr(1'b0, 12'h814, 64'hDEADBEEF, 1'b0, "R1 upper half write");
        rdchk(1'b1, 12'h810, 64'hDEADBEEF_33334444, 1'b0, "R1 merged entry");
        rdchk(1'b0, 12'h810, 64'h33334444, 1'b0, "R1 lower half read");
        rdchk(1'b0, 12'h814, 64'hDEADBEEF, 1'b0, "R1 upper half read");
        // R4 hard-fail paths
        wr(1'b1, 12'h800, 64'd32, 1'b0, "R4 index write");
        rdchk(1'b1, 12'h810, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R4 out-of-range read");
        wr(1'b1, 12'h810, 64'h0, 1'b1, "R4 out-of-range write");
        rdchk(1'b1, 12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R4 unmapped read");
        rdchk(1'b1, 12'h840, 64'h0, 1'b0, "R4 eoi read");
        read_entry(5, 64'hDEADBEEF_33334444, "R4 write ignored");
        // R6 masked line (line 6 default masked)
        irq_in[6] = 1'b1; step(3);
        check("R6 masked rise no latch", {56'h0, latched}, 64'h0);
        irq_in[6] = 1'b0; step(1);
        // R5 enabled line 0, vector 33 -> bit 1, held while stalled (R8)
        set_entry(16, 64'h0A021);
        msg_ready = 1'b0;
        expect_msg(32'hFFFA0000, 6'd33);
        irq_in[0] = 1'b1; step(2);
        check("R5 latched bit", {56'h0, latched}, 64'h02);
        check("R8 held", {63'h0, msg_valid}, 64'h1);
        step(2);
        check("R8 still held", {63'h0, msg_valid}, 64'h1);
        msg_ready = 1'b1; step(2);
        check("R8 drained", {63'h0, msg_valid}, 64'h0);
        // R6 falling edge clears, R5 re-rise sends again
        irq_in[0] = 1'b0; step(2);
        check("R6 fall clears", {56'h0, latched}, 64'h0);
        expect_msg(32'hFFFA0000, 6'd33);
        irq_in[0] = 1'b1; step(2);
        check("R5 re-latched", {56'h0, latched}, 64'h02);
        // R5 shared bit: line1 vector 41 -> bit 1 already set, no message; custom dest
        set_entry(19, 64'h12340000);
        set_entry(18, 64'h0A029);
        irq_in[1] = 1'b1; step(3);
        check("R5 shared bit no message", 64'(exp_addr.size()), 64'h0);
        // R7 end-of-interrupt by vector 41 clears bit of line index 1
        wr(1'b1, 12'h840, 64'd41, 1'b0, "R7 eoi write");
        check("R7 eoi clears", {56'h0, latched}, 64'h0);
        // R11 lines held high: no new message
        step(5);
        check("R11 no retrigger", {63'h0, msg_valid}, 64'h0);
        irq_in[1:0] = 2'b00; step(2);
        // R8 ordering: lines 2 and 3 together while stalled
        set_entry(20, 64'h0A002);
        set_entry(22, 64'h0A003);
        msg_ready = 1'b0;
        expect_msg(32'hFFFA0000, 6'd2);
        expect_msg(32'hFFFA0000, 6'd3);
        irq_in[3:2] = 2'b11; step(2);
        check("R5 two bits latched", {56'h0, latched}, 64'h0C);
        check("R8 lowest first", {58'h0, msg_data}, 64'd2);
        msg_ready = 1'b1; step(3);
        check("R8 both sent", 64'(exp_addr.size()), 64'h0);
        wr(1'b1, 12'h840, 64'd2, 1'b0, "R7 eoi write");
        check("R7 eoi vector 2", {56'h0, latched}, 64'h08);
        irq_in[3:2] = 2'b00; step(2);
        check("R6 falls clear", {56'h0, latched}, 64'h0);
        // R9 custom destination, vector 63 -> bit 7
        set_entry(27, 64'h5A3C0000);
        set_entry(26, 64'h0A03F);
        expect_msg(32'hF3C5A000, 6'd63);
        irq_in[5] = 1'b1; step(2);
        check("R9 latched bit 7", {56'h0, latched}, 64'h80);
        step(2);
        irq_in[5] = 1'b0; step(2);
        // R5 zero destination blocks latch
        set_entry(25, 64'h0);
        set_entry(24, 64'h0A004);
        irq_in[4] = 1'b1; step(3);
        check("R5 zero dest no latch", {56'h0, latched}, 64'h0);
        irq_in[4] = 1'b0; step(2);
        check("R9 scoreboard empty", 64'(exp_addr.size()), 64'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule